// File: doc/BRIEF.md
# Coalescing Store Queue for a Write-Through Cache

This block sits between a write-through cache and a slower lower-level memory. The processor side hands it stores, each made of a word address, a 32-bit word and four byte enables. Once a store is accepted, the processor treats it as done. The queue then writes whole lines back to memory, oldest first, through a request/acknowledge port. Each queued line is 16 bytes: four words with a valid bit per byte. A store whose line is already waiting in the queue is folded into that entry instead of taking a new slot. This turns several single-word writes into one multi-byte transfer.

A read-miss path can probe the queue with a lookup port before it goes to memory. If no queued line matches, the read may go ahead of the pending writes. If the newest matching line holds every requested byte, the queue returns the word directly. If a matching line lacks some requested byte, the block raises a stall so that the read waits for that line to retire.

The line at the front of the queue is presented to memory as soon as it becomes oldest. From then on it is frozen: no store may merge into it. Four entries are provided. When all are taken, a store with no merge target is held off.

Top module: `wt_coalesce_buf`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `mem_req`=0, `st_ready`=1, and no lookup reports a hit or a stall.
- R2: Lines are written to memory in the order their entries were created. `mem_addr` carries the line address with its 4 low bits zero.
- R3: For a retiring line, `mem_be` bit 4*w+b is set exactly for byte b of word w (word index = address bits [3:2]) that some store enabled. `mem_data` bits [(4*w+b)*8 +: 8] hold the newest value written to that byte.
- R4: A store to the line of a queued entry other than the front one merges into that entry. Only the enabled bytes change, later writes replace earlier ones, and occupancy does not grow.
- R5: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_data` and `mem_be` stay unchanged. A store to the front line takes a new entry instead of merging.
- R6: Capacity is 4 entries, and `full` is high when all four are taken. When full, a store with no merge target sees `st_ready`=0 and is not queued, while a store with a merge target is accepted.
- R7: On a lookup whose line matches a queued entry, where the newest such entry holds every byte requested by `lk_be` in word `lk_addr[3:2]`, `lk_hit`=1, `lk_stall`=0, and the enabled lanes of `lk_data` carry that entry's bytes.
- R8: When a lookup matches a line but the newest matching entry lacks some requested byte, `lk_stall`=1 and `lk_hit`=0.
- R9: A lookup matching no queued line drives both `lk_hit` and `lk_stall` low.
- R10: `mem_req` is high exactly when `empty` is low.
- R11: A store accepted in the same cycle that the front line is acknowledged takes effect together with the retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | 32 | Store byte address (bits [1:0] ignored) |
| st_data | input | 32 | Store word |
| st_be | input | 4 | Store byte enables |
| st_ready | output | 1 | Store accepted this cycle when high |
| lk_addr | input | 32 | Read-miss probe address |
| lk_be | input | 4 | Bytes the read needs |
| lk_hit | output | 1 | Probe fully served from the queue |
| lk_stall | output | 1 | Probe matches a line that cannot serve it |
| lk_data | output | 32 | Forwarded word |
| mem_req | output | 1 | Front line offered to memory |
| mem_addr | output | 32 | Line-aligned address of the front line |
| mem_data | output | 128 | Line data |
| mem_be | output | 16 | Byte enables of the line |
| mem_ack | input | 1 | Memory took the front line |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entry occupied |

## Verification
A retirement and a new store can land on the same clock edge. The new store may either merge into a younger line or claim a fresh slot while the front slot is being freed. The bench raises `st_valid` and `mem_ack` together in both forms. It then drains the queue and compares every retired line, its address, byte mask and bytes, against a reference queue kept in the bench. A held request is also combined with merges into younger entries, and the assertion on front-line stability judges that case cycle by cycle.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned LANE_W   = 8;
    localparam int unsigned WORD_BYT = WORD_W / LANE_W;
endpackage

// File: rtl/wcb_tag_cmp.sv
module wcb_tag_cmp #(
    parameter int unsigned TAG_W = 28
) (
    input  logic             slot_vld,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [TAG_W-1:0] probe_st,
    input  logic [TAG_W-1:0] probe_lk,
    output logic             match_st,
    output logic             match_lk
);
    always_comb begin
        match_st = slot_vld && (slot_tag == probe_st);
        match_lk = slot_vld && (slot_tag == probe_lk);
    end
endmodule

// File: rtl/wt_coalesce_buf.sv
module wt_coalesce_buf
    import wcb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DEPTH      = 4,   // power of two
    parameter int unsigned LINE_WORDS = 4    // power of two, >= 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             st_valid,
    input  logic [ADDR_W-1:0]                st_addr,
    input  logic [WORD_W-1:0]                st_data,
    input  logic [WORD_BYT-1:0]              st_be,
    output logic                             st_ready,
    input  logic [ADDR_W-1:0]                lk_addr,
    input  logic [WORD_BYT-1:0]              lk_be,
    output logic                             lk_hit,
    output logic                             lk_stall,
    output logic [WORD_W-1:0]                lk_data,
    output logic                             mem_req,
    output logic [ADDR_W-1:0]                mem_addr,
    output logic [LINE_WORDS*WORD_W-1:0]     mem_data,
    output logic [LINE_WORDS*WORD_BYT-1:0]   mem_be,
    input  logic                             mem_ack,
    output logic                             full,
    output logic                             empty
);
    localparam int unsigned LINE_BYT = LINE_WORDS * WORD_BYT;
    localparam int unsigned LINE_W   = LINE_BYT * LANE_W;
    localparam int unsigned OFF_W    = $clog2(LINE_BYT);
    localparam int unsigned LSEL_W   = $clog2(WORD_BYT);
    localparam int unsigned WSEL_W   = $clog2(LINE_WORDS);
    localparam int unsigned TAG_W    = ADDR_W - OFF_W;
    localparam int unsigned PTR_W    = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]                vld;
        logic [DEPTH-1:0][TAG_W-1:0]     tag;
        logic [DEPTH-1:0][LINE_W-1:0]    data;
        logic [DEPTH-1:0][LINE_BYT-1:0]  bmask;
        logic [PTR_W-1:0]                head;
        logic [PTR_W-1:0]                tail;
    } wq_state_t;

    wq_state_t s_q, s_d;

    logic [TAG_W-1:0]  st_tag, lk_tag;
    logic [WSEL_W-1:0] st_word, lk_word;
    logic [DEPTH-1:0]  st_match, lk_match;

    assign st_tag  = st_addr[ADDR_W-1:OFF_W];
    assign lk_tag  = lk_addr[ADDR_W-1:OFF_W];
    assign st_word = st_addr[OFF_W-1:LSEL_W];
    assign lk_word = lk_addr[OFF_W-1:LSEL_W];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        wcb_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
            .slot_vld (s_q.vld[g]),
            .slot_tag (s_q.tag[g]),
            .probe_st (st_tag),
            .probe_lk (lk_tag),
            .match_st (st_match[g]),
            .match_lk (lk_match[g])
        );
    end

    // merge target: any matching slot except the locked front one
    logic             merge_ok;
    logic [PTR_W-1:0] merge_idx;
    always_comb begin
        merge_ok  = 1'b0;
        merge_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_match[i] && (PTR_W'(i) != s_q.head)) begin
                merge_ok  = 1'b1;
                merge_idx = PTR_W'(i);
            end
        end
    end

    // lookup: walk from oldest to newest, newest match wins
    logic             lk_any;
    logic [PTR_W-1:0] lk_sel;
    logic [PTR_W-1:0] lk_pos;
    logic [LINE_BYT-1:0] lk_need;
    always_comb begin
        lk_any = 1'b0;
        lk_sel = '0;
        lk_pos = '0;
        for (int k = 0; k < DEPTH; k++) begin
            lk_pos = s_q.head + PTR_W'(k);
            if (lk_match[lk_pos]) begin
                lk_any = 1'b1;
                lk_sel = lk_pos;
            end
        end
        lk_need  = LINE_BYT'(lk_be) << (int'(lk_word) * WORD_BYT);
        lk_hit   = lk_any && ((s_q.bmask[lk_sel] & lk_need) == lk_need);
        lk_stall = lk_any && ((s_q.bmask[lk_sel] & lk_need) != lk_need);
        lk_data  = s_q.data[lk_sel][int'(lk_word)*WORD_W +: WORD_W];
    end

    assign full     = &s_q.vld;
    assign empty    = ~|s_q.vld;
    assign mem_req  = s_q.vld[s_q.head];
    assign mem_addr = {s_q.tag[s_q.head], {OFF_W{1'b0}}};
    assign mem_data = s_q.data[s_q.head];
    assign mem_be   = s_q.bmask[s_q.head];
    assign st_ready = merge_ok || !full;

    logic [PTR_W-1:0] tgt;
    always_comb begin
        s_d = s_q;
        tgt = merge_ok ? merge_idx : s_q.tail;
        if (mem_req && mem_ack) begin
            s_d.vld[s_q.head]   = 1'b0;
            s_d.bmask[s_q.head] = '0;
            s_d.head            = s_q.head + 1'b1;
        end
        if (st_valid && st_ready) begin
            if (!merge_ok) begin
                s_d.vld[tgt]   = 1'b1;
                s_d.tag[tgt]   = st_tag;
                s_d.bmask[tgt] = '0;
                s_d.data[tgt]  = '0;
                s_d.tail       = s_q.tail + 1'b1;
            end
            for (int b = 0; b < WORD_BYT; b++) begin
                if (st_be[b]) begin
                    s_d.data[tgt][(int'(st_word)*WORD_BYT + b)*LANE_W +: LANE_W] =
                        st_data[b*LANE_W +: LANE_W];
                    s_d.bmask[tgt][int'(st_word)*WORD_BYT + b] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // front line is frozen while its request waits
    a_r5_front_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_data) && $stable(mem_be)));

    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(mem_req && mem_ack)) |=> full);

    a_r8_hit_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_stall));

    a_r9_empty_no_probe: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (!lk_hit && !lk_stall));

    a_r10_req_vs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req == !empty);
endmodule

// File: tb/wt_coalesce_buf_test.sv
module wt_coalesce_buf_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic [31:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic [3:0]   st_be = '0;
    logic         st_ready;
    logic [31:0]  lk_addr = '0;
    logic [3:0]   lk_be = '0;
    logic         lk_hit, lk_stall;
    logic [31:0]  lk_data;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic [127:0] mem_data;
    logic [15:0]  mem_be;
    logic         mem_ack = 1'b0;
    logic         full, empty;

    int n_chk = 0;
    int n_bad = 0;

    // reference queue, slot 0 is the front line
    logic [27:0]  m_tag [8];
    logic [15:0]  m_be  [8];
    logic [127:0] m_dat [8];
    int           m_cnt = 0;

    wt_coalesce_buf uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_ready(st_ready),
        .lk_addr(lk_addr), .lk_be(lk_be), .lk_hit(lk_hit), .lk_stall(lk_stall),
        .lk_data(lk_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .mem_ack(mem_ack), .full(full), .empty(empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int merge_slot(input logic [31:0] a);
        int r = -1;
        for (int j = 1; j < m_cnt; j++) if (m_tag[j] == a[31:4]) r = j;
        return r;
    endfunction

    task automatic model_store(input logic [31:0] a, input logic [31:0] d,
                               input logic [3:0] be);
        int s = merge_slot(a);
        if (s < 0) begin
            s = m_cnt; m_cnt++;
            m_tag[s] = a[31:4]; m_be[s] = '0; m_dat[s] = '0;
        end
        for (int b = 0; b < 4; b++) if (be[b]) begin
            m_be[s][a[3:2]*4 + b] = 1'b1;
            m_dat[s][(a[3:2]*4 + b)*8 +: 8] = d[b*8 +: 8];
        end
    endtask

    task automatic model_pop();
        for (int j = 0; j < 7; j++) begin
            m_tag[j] = m_tag[j+1]; m_be[j] = m_be[j+1]; m_dat[j] = m_dat[j+1];
        end
        m_cnt--;
    endtask

    function automatic logic [127:0] expand(input logic [15:0] be);
        logic [127:0] m = '0;
        for (int b = 0; b < 16; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic check_front();
        logic [127:0] msk;
        chk(mem_req === 1'b1, "R10 mem_req", {127'd0, mem_req}, 128'd1);
        chk(mem_addr === {m_tag[0], 4'h0}, "R2 order/addr", {96'd0, mem_addr},
            {96'd0, m_tag[0], 4'h0});
        chk(mem_be === m_be[0], "R3 mem_be", {112'd0, mem_be}, {112'd0, m_be[0]});
        msk = expand(m_be[0]);
        chk((mem_data & msk) === (m_dat[0] & msk), "R3 mem_data",
            mem_data & msk, m_dat[0] & msk);
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] be, input string req);
        bit exp_rdy;
        @(negedge clk);
        exp_rdy = (merge_slot(a) >= 0) || (m_cnt < 4);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        #1;
        chk(st_ready === exp_rdy, req, {127'd0, st_ready}, {127'd0, exp_rdy});
        @(posedge clk);
        if (exp_rdy) model_store(a, d, be);
        #1 st_valid = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        check_front();
        mem_ack = 1'b1;
        @(posedge clk);
        model_pop();
        #1 mem_ack = 1'b0;
    endtask

    // R11: store and retirement on the same edge
    task automatic do_both(input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] be);
        bit exp_rdy;
        @(negedge clk);
        check_front();
        exp_rdy = (merge_slot(a) >= 0) || (m_cnt < 4);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; mem_ack = 1'b1;
        #1;
        chk(st_ready === exp_rdy, "R11 ready with ack", {127'd0, st_ready},
            {127'd0, exp_rdy});
        @(posedge clk);
        if (exp_rdy) model_store(a, d, be);
        model_pop();
        #1 begin st_valid = 1'b0; mem_ack = 1'b0; end
    endtask

    task automatic do_look(input logic [31:0] a, input logic [3:0] be);
        int f = -1;
        logic [15:0] need;
        bit eh, es;
        @(negedge clk);
        lk_addr = a; lk_be = be;
        #1;
        for (int j = 0; j < m_cnt; j++) if (m_tag[j] == a[31:4]) f = j;
        need = 16'(be) << (a[3:2]*4);
        eh = (f >= 0) && ((m_be[f] & need) == need);
        es = (f >= 0) && !eh;
        if (f < 0)
            chk(!lk_hit && !lk_stall, "R9 no match", {126'd0, lk_hit, lk_stall}, 128'd0);
        else if (eh)
            chk(lk_hit && !lk_stall, "R7 full hit", {126'd0, lk_hit, lk_stall}, 128'd2);
        else
            chk(!lk_hit && lk_stall, "R8 partial", {126'd0, lk_hit, lk_stall}, 128'd1);
        if (eh) for (int b = 0; b < 4; b++) if (be[b])
            chk(lk_data[b*8 +: 8] === m_dat[f][(a[3:2]*4 + b)*8 +: 8], "R7 data",
                {120'd0, lk_data[b*8 +: 8]}, {120'd0, m_dat[f][(a[3:2]*4 + b)*8 +: 8]});
    endtask

    task automatic drain();
        while (m_cnt > 0) do_ack();
        @(negedge clk);
        chk(empty === 1'b1 && mem_req === 1'b0, "R10 empty after drain",
            {126'd0, empty, mem_req}, 128'd2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(empty === 1'b1, "R1 empty", {127'd0, empty}, 128'd1);
        chk(full === 1'b0, "R1 full", {127'd0, full}, 128'd0);
        chk(mem_req === 1'b0, "R1 mem_req", {127'd0, mem_req}, 128'd0);
        chk(st_ready === 1'b1, "R1 st_ready", {127'd0, st_ready}, 128'd1);
        do_look(32'h0000_0000, 4'hF);

        // byte-enable sweep: every store mask against every probe mask
        for (int be = 1; be < 16; be++) begin
            for (int w = 0; w < 4; w++) begin
                do_store(32'h0000_1000 + be*64 + w*4, 32'hA0B0C0D0 ^ (be << 8 | w),
                         4'(be), "R4 sweep accept");
                for (int lb = 1; lb < 16; lb++)
                    do_look(32'h0000_1000 + be*64 + w*4, 4'(lb));
                do_look(32'h0000_1000 + be*64 + ((w+1)%4)*4, 4'hF);
                do_look(32'h0000_9000, 4'hF);
                drain();
            end
        end

        // capacity, full-merge and front lock
        do_store(32'h0000_2000, 32'h11111111, 4'hF, "R2 fill A");
        do_store(32'h0000_2010, 32'h22222222, 4'hF, "R2 fill B");
        do_store(32'h0000_2020, 32'h33333333, 4'h3, "R2 fill C");
        do_store(32'h0000_2030, 32'h44444444, 4'hF, "R2 fill D");
        @(negedge clk);
        chk(full === 1'b1, "R6 full flag", {127'd0, full}, 128'd1);
        do_store(32'h0000_2040, 32'h55555555, 4'hF, "R6 blocked when full");
        do_store(32'h0000_2024, 32'h66666666, 4'hC, "R6 merge when full");
        do_store(32'h0000_2004, 32'h77777777, 4'hF, "R5 front not mergeable");
        do_look(32'h0000_2024, 4'hC);
        do_look(32'h0000_2020, 4'hF);
        drain();

        // merge overwrite, then front re-store takes a new entry
        do_store(32'h0000_3000, 32'h0000BEEF, 4'h3, "R4 A");
        do_store(32'h0000_3104, 32'hCAFEF00D, 4'hF, "R4 B word1");
        do_store(32'h0000_3104, 32'h000000AA, 4'h1, "R4 B overwrite");
        do_store(32'h0000_3108, 32'h12345678, 4'h6, "R4 B word2");
        do_look(32'h0000_3104, 4'hF);
        do_look(32'h0000_3108, 4'hF);
        do_look(32'h0000_3000, 4'h3);
        do_store(32'h0000_3000, 32'h99990000, 4'hC, "R5 new entry for front line");
        do_look(32'h0000_3000, 4'h3);
        do_look(32'h0000_3000, 4'hC);
        drain();

        // R11 same-edge store and retirement
        do_store(32'h0000_4000, 32'h01010101, 4'hF, "R11 A");
        do_store(32'h0000_4010, 32'h02020202, 4'hF, "R11 B");
        do_both(32'h0000_4014, 32'h03030303, 4'hF);
        do_both(32'h0000_4020, 32'h04040404, 4'h5);
        do_store(32'h0000_4030, 32'h05050505, 4'hF, "R11 C");
        do_store(32'h0000_4040, 32'h06060606, 4'hF, "R11 D");
        do_store(32'h0000_4050, 32'h07070707, 4'hF, "R11 E");
        do_both(32'h0000_4060, 32'h08080808, 4'hF);
        drain();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule